// File: doc/BRIEF.md
# Stuck Bus Recovery Sequencer

This block sits beside the connection switch of a two-wire (I2C style) bus buffer and watches the downstream clock and data lines. If either line stays low longer than a programmable timeout, it raises a fault and asks the buffer to open both paths. After a settling gap it clocks the downstream bus with a burst of open-drain pulses so that a slave stuck mid-byte can finish and release data. It then issues a stop condition. When the bus is seen idle again, the fault is dropped and the buffer may reconnect.

An enable input gates the automatic clocking. A rising edge on enable while a fault is pending forces the fault clear at once, even if the bus is still stuck. The timeout counters restart at that edge and stay armed. A supply-good flag holds the timers until power is valid, so a bus that is stuck at power-up is clocked one timeout after supply-good. Durations are parameters in system clock cycles.

Top module: `stuck_bus_recovery`

## Requirements
- R1: Each line has its own timer that counts while that synchronized line is low. When the timer reaches TIMEOUT_CYC cycles, a fault is raised. Any return of the line high restarts its count from zero, so two short lows separated by a high never add up.
- R2: While a fault is pending, `fault` is 1 and `disconnect_req` is 1.
- R3: The first SCL pull-down starts exactly GAP_CYC cycles after `fault` rises. Each pulse pulls SCL low for HALF_CYC cycles and releases it for HALF_CYC cycles, giving a period of 2*HALF_CYC.
- R4: After NUM_PULSES pulses, a stop is generated in three phases of HALF_CYC each. In the first phase SCL and SDA are both pulled low. In the second, SCL is released and SDA stays low. In the third, SDA is released while SCL stays released. This gives NUM_PULSES+1 SCL pull-downs per episode.
- R5: When both synchronized lines are high while the block waits (before the burst or after the stop), the fault clears and `disconnect_req` drops. If the line stays stuck, the fault is held with both pulls released.
- R6: While `enable` is 0, `scl_pull` and `sda_pull` stay 0 and `disconnect_req` is 1. A running burst is abandoned, and no pulses start.
- R7: A rising edge of `enable` while a fault is pending clears the fault in the next cycle, even if the bus is still low. Both timers restart at that edge, so a bus that is still stuck faults again after a further timeout.
- R8: While `pwr_good` is 0, the timers do not count and `disconnect_req` is 1. Counting begins when `pwr_good` rises.
- R9: `accel_inhibit` is 1 throughout the pulse burst and the stop, and whenever `connected` is 0. Otherwise it is 0.
- R10: The burst ends early and proceeds to the stop if, at the end of a released half-period, both synchronized SDA and SCL are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw downstream SCL level (1 = high) |
| sda_in | input | 1 | Raw downstream SDA level (1 = high) |
| enable | input | 1 | Connection enable; low inhibits clocking |
| pwr_good | input | 1 | Supply valid flag |
| connected | input | 1 | Buffer paths currently joined |
| disconnect_req | output | 1 | Request to open both buffer paths |
| fault | output | 1 | Stuck-bus fault pending (drives ready low) |
| scl_pull | output | 1 | 1 = pull downstream SCL low |
| sda_pull | output | 1 | 1 = pull downstream SDA low |
| accel_inhibit | output | 1 | 1 = rise-time accelerators off |

## Verification
The enable-edge override and the pulse burst can act in the same window. Both claim the state of the sequencer, and the override must win. The bench provokes this by holding SDA low until the burst has issued its third SCL pull-down. It then drops `enable` for one cycle and raises it again. The result is judged in three ways: the SCL pull-down count for that episode must be exactly three; fault and accelerator inhibit must clear while SDA is still held low; and a fresh full timeout must raise the fault again.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PULSE,
    ST_STP_LO,
    ST_STP_SCL,
    ST_STP_SDA,
    ST_DONE
  } rec_state_e;
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        out_q  <= 1'b1;
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end
endmodule

// File: rtl/brc_low_timer.sv
module brc_low_timer #(
  parameter int TIMEOUT_CYC = 7_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low,
  input  logic run,
  input  logic clr,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expire  = run && line_low && at_last && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run || !line_low) cnt_d = '0;
    else if (!at_last)            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: an override edge restarts the count
  a_r7_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int GAP_CYC    = 10_000,
  parameter int HALF_CYC   = 14_706,
  parameter int NUM_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic enable,
  input  logic en_rise,
  input  logic bus_high,
  output logic fault,
  output logic seq_active,
  output logic scl_drive,
  output logic sda_drive
);
  localparam int GW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
  localparam int HW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
  localparam logic [PW-1:0] P_LAST    = PW'(NUM_PULSES - 1);
  localparam logic [PW-1:0] P_MAX     = PW'(NUM_PULSES);

  rec_state_e    state_q, state_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          ph_q, ph_d;
  logic          half_end, burst_state, stop_state;

  assign half_end    = (hcnt_q == HALF_LAST);
  assign stop_state  = (state_q == ST_STP_LO) || (state_q == ST_STP_SCL) ||
                       (state_q == ST_STP_SDA);
  assign burst_state = (state_q == ST_PULSE) || stop_state;

  always_comb begin
    state_d = state_q;
    gcnt_d  = gcnt_q;
    hcnt_d  = hcnt_q;
    pcnt_d  = pcnt_q;
    ph_d    = ph_q;
    case (state_q)
      ST_IDLE: if (expire) begin
        state_d = ST_WAIT;
        gcnt_d  = '0;
      end
      ST_WAIT: begin
        if (gcnt_q != GAP_LAST) gcnt_d = gcnt_q + 1'b1;
        else if (enable) begin
          state_d = ST_PULSE;
          hcnt_d  = '0;
          pcnt_d  = '0;
          ph_d    = 1'b0;
        end
      end
      ST_PULSE: begin
        hcnt_d = half_end ? '0 : hcnt_q + 1'b1;
        if (half_end) begin
          if (!ph_q) ph_d = 1'b1;
          else begin
            ph_d   = 1'b0;
            pcnt_d = pcnt_q + 1'b1;
            if (pcnt_q == P_LAST || bus_high) state_d = ST_STP_LO;
          end
        end
      end
      ST_STP_LO, ST_STP_SCL, ST_STP_SDA: begin
        hcnt_d = half_end ? '0 : hcnt_q + 1'b1;
        if (half_end) begin
          if (state_q == ST_STP_LO)       state_d = ST_STP_SCL;
          else if (state_q == ST_STP_SCL) state_d = ST_STP_SDA;
          else                            state_d = ST_DONE;
        end
      end
      default: ;
    endcase
    if ((state_q == ST_WAIT || state_q == ST_DONE) && bus_high) state_d = ST_IDLE;
    if (!enable && burst_state) begin
      state_d = ST_WAIT;
      gcnt_d  = '0;
    end
    if (en_rise && state_q != ST_IDLE) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gcnt_q  <= '0;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
      ph_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      gcnt_q  <= gcnt_d;
      hcnt_q  <= hcnt_d;
      pcnt_q  <= pcnt_d;
      ph_q    <= ph_d;
    end
  end

  assign fault      = (state_q != ST_IDLE);
  assign seq_active = burst_state;
  assign scl_drive  = ((state_q == ST_PULSE) && !ph_q) || (state_q == ST_STP_LO);
  assign sda_drive  = (state_q == ST_STP_LO) || (state_q == ST_STP_SCL);

  a_r1_fault_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(expire));
  a_r3_no_pull_at_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |=> !scl_drive);
  a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= P_MAX);
  a_r5_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(bus_high || en_rise));
  a_r6_abort_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !seq_active);
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int TIMEOUT_CYC = 7_500_000,
  parameter int GAP_CYC     = 10_000,
  parameter int HALF_CYC    = 14_706,
  parameter int NUM_PULSES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic enable,
  input  logic pwr_good,
  input  logic connected,
  output logic disconnect_req,
  output logic fault,
  output logic scl_pull,
  output logic sda_pull,
  output logic accel_inhibit
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_bus, s_bus, exp_vec;
  logic             en_q, en_rise, fault_w, seq_active, scl_drv, sda_drv, run;

  assign raw_bus = {sda_in, scl_in};

  brc_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(s_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end
  assign en_rise = enable && !en_q;
  assign run     = pwr_good && !fault_w;

  for (genvar i = 0; i < NLINE; i++) begin : g_timer
    brc_low_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .line_low(!s_bus[i]), .run(run),
      .clr(en_rise), .expire(exp_vec[i])
    );
  end

  brc_seq #(
    .GAP_CYC(GAP_CYC), .HALF_CYC(HALF_CYC), .NUM_PULSES(NUM_PULSES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .expire(|exp_vec), .enable(enable),
    .en_rise(en_rise), .bus_high(&s_bus), .fault(fault_w),
    .seq_active(seq_active), .scl_drive(scl_drv), .sda_drive(sda_drv)
  );

  assign fault          = fault_w;
  assign disconnect_req = fault_w || !enable || !pwr_good;
  assign scl_pull       = scl_drv && enable;
  assign sda_pull       = sda_drv && enable;
  assign accel_inhibit  = seq_active || !connected;

  // R8: no new fault can appear while the supply is not good
  a_r8_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !fault_w) |=> !fault_w);
endmodule

// File: tb/stuck_bus_recovery_bench.sv
`timescale 1ns/1ps
module stuck_bus_recovery_bench;
  localparam int TO = 40, GAP = 6, HALF = 4, NP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, pwr_good = 1'b1, connected = 1'b1;
  logic scl_stuck = 1'b0, sda_stuck = 1'b0;
  logic scl_in, sda_in, disconnect_req, fault, scl_pull, sda_pull, accel_inhibit;

  assign scl_in = ~(scl_pull | scl_stuck);
  assign sda_in = ~(sda_pull | sda_stuck);

  stuck_bus_recovery #(
    .TIMEOUT_CYC(TO), .GAP_CYC(GAP), .HALF_CYC(HALF), .NUM_PULSES(NP)
  ) u_stuck_bus_recovery (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .enable(enable), .pwr_good(pwr_good), .connected(connected),
    .disconnect_req(disconnect_req), .fault(fault), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .accel_inhibit(accel_inhibit)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string tag_q[$];
  int exp_q[$];
  int rise_cnt = 0, gap_meas = 0, period_meas = 0, pull_w = 0, accel_bad = 0;
  int fault_t = 0, first_rise_t = 0;
  bit stop_seen = 1'b0;
  logic pf = 1'b0, ps = 1'b0, pd = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected SCL pull-downs in the next episode
  task automatic expect_pulses(input string tag, input int n);
    tag_q.push_back(tag);
    exp_q.push_back(n);
  endtask

  task automatic wait_fault(input int lim, output int n);
    n = 0;
    while (!fault && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_clear(input int lim);
    for (int k = 0; k < lim && fault; k++) @(negedge clk);
  endtask

  // monitor side: measures each episode and pops its expectation when it ends
  always @(negedge clk) begin
    string t;
    int e;
    cyc++;
    if (rst_n) begin
      if (fault && !pf) begin
        fault_t   = cyc;
        rise_cnt  = 0;
        stop_seen = 1'b0;
      end
      if (scl_pull && !ps) begin
        rise_cnt++;
        if (rise_cnt == 1) begin
          gap_meas     = cyc - fault_t;
          first_rise_t = cyc;
        end
        if (rise_cnt == 2) period_meas = cyc - first_rise_t;
        if (!accel_inhibit) accel_bad++;
      end
      if (!scl_pull && ps && rise_cnt == 1) pull_w = cyc - first_rise_t;
      if (!sda_pull && pd && !scl_pull) stop_seen = 1'b1;
      if (!fault && pf) begin
        if (exp_q.size() == 0) check("R5 unexpected episode end", 1, 0);
        else begin
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          check(t, rise_cnt, e);
        end
      end
    end
    pf = fault;
    ps = scl_pull;
    pd = sda_pull;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset fault", fault, 0);
    check("R2 reset disconnect", disconnect_req, 0);
    check("R3 reset scl_pull", scl_pull, 0);
    check("R4 reset sda_pull", sda_pull, 0);
    check("R9 reset accel", accel_inhibit, 0);

    // R1: two short lows on the same line never accumulate
    sda_stuck = 1'b1; repeat (TO - 5) @(negedge clk);
    sda_stuck = 1'b0; repeat (6) @(negedge clk);
    sda_stuck = 1'b1; repeat (TO - 5) @(negedge clk);
    check("R1 short lows no fault", fault, 0);
    sda_stuck = 1'b0; repeat (6) @(negedge clk);

    // full burst with SDA held low throughout
    expect_pulses("R4 full burst count", NP + 1);
    sda_stuck = 1'b1;
    wait_fault(TO + 10, n);
    check("R1 timeout window", int'(n >= TO && n <= TO + 4), 1);
    check("R2 disconnect on fault", disconnect_req, 1);
    wait (rise_cnt == 3);
    @(negedge clk);
    check("R3 gap to first pull", gap_meas, GAP);
    check("R3 pulse period", period_meas, 2 * HALF);
    check("R3 low half width", pull_w, HALF);
    check("R9 accel during burst", accel_inhibit, 1);
    wait (rise_cnt == NP + 1);
    repeat (3 * HALF + 6) @(negedge clk);
    check("R5 fault held while stuck", fault, 1);
    check("R5 pulls released while stuck", int'(scl_pull | sda_pull), 0);
    check("R9 accel after burst", accel_inhibit, 0);
    check("R9 accel on every pulse", accel_bad, 0);
    sda_stuck = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 clear after release", fault, 0);
    check("R5 disconnect drops", disconnect_req, 0);

    // early stop: slave lets go of SDA on the fifth pulse
    expect_pulses("R10 early stop count", 6);
    sda_stuck = 1'b1;
    wait_fault(TO + 10, n);
    wait (rise_cnt == 5);
    @(negedge clk);
    sda_stuck = 1'b0;
    wait_clear(200);
    check("R4 stop condition seen", int'(stop_seen), 1);
    check("R10 fault cleared", fault, 0);

    // supply not good holds the timers
    pwr_good = 1'b0; sda_stuck = 1'b1;
    repeat (3 * TO) @(negedge clk);
    check("R8 no fault unpowered", fault, 0);
    check("R8 disconnect unpowered", disconnect_req, 1);
    expect_pulses("R5 release during gap", 0);
    pwr_good = 1'b1;
    wait_fault(TO + 10, n);
    check("R8 timeout from pwr_good", int'(n >= TO - 1 && n <= TO + 2), 1);
    sda_stuck = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 cleared before burst", fault, 0);

    // enable low: no clocking; enable edge overrides
    enable = 1'b0;
    #1 check("R6 disconnect when disabled", disconnect_req, 1);
    expect_pulses("R6 no clocking while disabled", 0);
    scl_stuck = 1'b1;
    wait_fault(TO + 10, n);
    repeat (GAP + 40) @(negedge clk);
    check("R6 no pull while disabled", int'(scl_pull | (rise_cnt != 0)), 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 forced clear while stuck", fault, 0);
    expect_pulses("R7 rearmed burst", NP + 1);
    wait_fault(TO + 10, n);
    check("R7 timer rearmed", fault, 1);
    wait (rise_cnt == NP + 1);
    repeat (3 * HALF + 6) @(negedge clk);
    scl_stuck = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 clear after scl release", fault, 0);

    // override in the middle of a burst
    expect_pulses("R7 override mid burst", 3);
    sda_stuck = 1'b1;
    wait_fault(TO + 10, n);
    wait (rise_cnt == 3);
    @(negedge clk);
    enable = 1'b0;
    #1 check("R6 pull released at once", scl_pull, 0);
    @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 override clears fault", fault, 0);
    check("R9 accel after override", accel_inhibit, 0);
    expect_pulses("R5 release in wait", 0);
    wait_fault(TO + 10, n);
    check("R7 refault after override", fault, 1);
    sda_stuck = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 final clear", fault, 0);

    connected = 1'b0;
    #1 check("R9 accel when not connected", accel_inhibit, 1);
    connected = 1'b1;
    @(negedge clk);
    check("R4 all episodes closed", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule